// File: doc/BRIEF.md
# Segmented Real-Mode Address Generator

This block forms 20-bit physical addresses for a 16-bit processor core from a segment register and a 16-bit offset. It holds four 16-bit segment registers. Each one can be loaded on its own, and loading a new value is the only way to move the window of memory that an access can reach. To find the base of a segment, the block appends four zero bits below the register value. That puts every base on a 16-byte paragraph boundary. The offset is then added to the base.

A sum that goes past the top of the 1 MB space is cut to 20 bits, so it wraps back to the start of memory. A separate flag reports that the wrap happened. The block does not reject or flag overlapping segments, so many segment:offset pairs can name the same byte.

Each accepted request produces a registered result one clock later. In that result cycle the shared address/data bus carries the low 16 address bits and an address-latch strobe pulses high. In every other cycle the bus carries the data word supplied by the core.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset all four segment registers read as 0x0000, `pa_valid` and `ale` are low, and `ad_bus` carries `bus_dout`.
- R2: A request with `req_valid` high in cycle N yields `pa` = ((segment << 4) + `req_off`) mod 2^20 with `pa_valid` high in cycle N+1.
- R3: Select codes map 00 to the code segment, 01 to data, 10 to stack and 11 to extra. A write changes only the register that `wr_sel` names.
- R4: A segment write takes effect on the next clock. A request in the same cycle as a write to its selected register uses the old value.
- R5: When the 21-bit sum has bit 20 set, `pa_wrap` is high and `pa` is the sum minus 2^20. For example, 0xFFFF:0xFFFF gives 0x0FFEF with `pa_wrap` set.
- R6: Overlapping segments are accepted silently. Different pairs that name one address give the same `pa`, and `pa_wrap` stays low when no wrap occurs.
- R7: `pa_valid` is high only in the cycle after a request. `pa` and `pa_wrap` hold their values while no request is made.
- R8: While `pa_valid` is high, `ale` is high and `ad_bus` equals `pa[15:0]`. Otherwise `ale` is low and `ad_bus` equals `bus_dout`.
- R9: A request with offset 0 gives a paragraph-aligned address (`pa[3:0]` = 0) and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Segment register write strobe |
| wr_sel | input | 2 | Register to write (00 code, 01 data, 10 stack, 11 extra) |
| wr_data | input | 16 | New segment value |
| req_valid | input | 1 | Address request |
| req_sel | input | 2 | Segment register used by the request |
| req_off | input | 16 | Offset within the segment |
| bus_dout | input | 16 | Data word driven in data phase |
| pa | output | 20 | Registered physical address |
| pa_valid | output | 1 | Result valid this cycle |
| pa_wrap | output | 1 | Sum exceeded the 1 MB space |
| ale | output | 1 | Address latch enable |
| ad_bus | output | 16 | Multiplexed address/data bus |

## Verification
The bench builds the block with its default parameters: 16-bit segment and offset, a 4-bit shift and four registers. With these values the real 1 MB boundary is in reach, so it can drive the exact wrap corners 0xFFFF:0xFFFF and 0xF001:0xFFF0, and the largest non-wrapping sum 0xF000:0xFFFF. All four select codes can be exercised one by one. Pairs only 16 bytes apart in base can be made to alias the same byte.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  typedef enum logic [1:0] {
    SEG_CODE  = 2'b00,
    SEG_DATA  = 2'b01,
    SEG_STACK = 2'b10,
    SEG_EXTRA = 2'b11
  } seg_id_e;
endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/seg_regfile.sv
module seg_regfile #(
  parameter int SEG_W    = 16,
  parameter int NUM_SEGS = 4,
  localparam int SEL_W   = $clog2(NUM_SEGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [SEG_W-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [SEG_W-1:0] rd_data
);
  logic [SEG_W-1:0] seg_q [NUM_SEGS];
  logic [SEG_W-1:0] seg_d [NUM_SEGS];

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
    logic load;
    always_comb begin
      load     = wr_en && (wr_sel == SEL_W'(g));
      seg_d[g] = load ? wr_data : seg_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seg_q[g] <= '0;
      else        seg_q[g] <= seg_d[g];
    end
  end

  // read uses the current register value, so a same-cycle write is not seen
  assign rd_data = seg_q[rd_sel];
endmodule

// File: rtl/seg_addr_adder.sv
module seg_addr_adder #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  localparam int PA_W  = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  output logic [PA_W-1:0]  addr,
  output logic             wrap
);
  logic [PA_W:0] base_ext;
  logic [PA_W:0] off_ext;
  logic [PA_W:0] sum;

  always_comb begin
    base_ext = {1'b0, seg, {SHIFT{1'b0}}};
    off_ext  = {{(PA_W + 1 - OFF_W){1'b0}}, off};
    sum      = base_ext + off_ext;
    addr     = sum[PA_W-1:0];
    wrap     = sum[PA_W];
  end
endmodule

// File: rtl/seg_ad_mux.sv
module seg_ad_mux #(
  parameter int AD_W = 16,
  parameter int PA_W = 20
) (
  input  logic            phase_addr,
  input  logic [PA_W-1:0] pa,
  input  logic [AD_W-1:0] dout,
  output logic            ale,
  output logic [AD_W-1:0] ad
);
  always_comb begin
    ale = phase_addr;
    ad  = phase_addr ? pa[AD_W-1:0] : dout;
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int SEG_W    = 16,
  parameter int OFF_W    = 16,
  parameter int SHIFT    = 4,
  parameter int NUM_SEGS = 4,
  localparam int PA_W    = SEG_W + SHIFT,
  localparam int SEL_W   = $clog2(NUM_SEGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [SEG_W-1:0] wr_data,
  input  logic             req_valid,
  input  logic [SEL_W-1:0] req_sel,
  input  logic [OFF_W-1:0] req_off,
  input  logic [OFF_W-1:0] bus_dout,
  output logic [PA_W-1:0]  pa,
  output logic             pa_valid,
  output logic             pa_wrap,
  output logic             ale,
  output logic [OFF_W-1:0] ad_bus
);
  logic             rst_sync_n;
  logic [SEG_W-1:0] seg_val;
  logic [PA_W-1:0]  sum_addr;
  logic             sum_wrap;

  logic [PA_W-1:0]  pa_q, pa_d;
  logic             vld_q, vld_d;
  logic             wrap_q, wrap_d;

  seg_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  seg_regfile #(.SEG_W(SEG_W), .NUM_SEGS(NUM_SEGS)) rf_i (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(req_sel), .rd_data(seg_val)
  );

  seg_addr_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) add_i (
    .seg(seg_val), .off(req_off), .addr(sum_addr), .wrap(sum_wrap)
  );

  always_comb begin
    vld_d  = req_valid;
    pa_d   = req_valid ? sum_addr : pa_q;
    wrap_d = req_valid ? sum_wrap : wrap_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pa_q   <= '0;
      vld_q  <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      pa_q   <= pa_d;
      vld_q  <= vld_d;
      wrap_q <= wrap_d;
    end
  end

  seg_ad_mux #(.AD_W(OFF_W), .PA_W(PA_W)) mux_i (
    .phase_addr(vld_q), .pa(pa_q), .dout(bus_dout), .ale(ale), .ad(ad_bus)
  );

  assign pa       = pa_q;
  assign pa_valid = vld_q;
  assign pa_wrap  = wrap_q;
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int SEG_W    = 16,
  parameter int OFF_W    = 16,
  parameter int SHIFT    = 4,
  parameter int NUM_SEGS = 4,
  localparam int PA_W    = SEG_W + SHIFT,
  localparam int SEL_W   = $clog2(NUM_SEGS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [OFF_W-1:0] req_off,
  input logic [OFF_W-1:0] bus_dout,
  input logic [PA_W-1:0]  pa,
  input logic             pa_valid,
  input logic             pa_wrap,
  input logic             ale,
  input logic [OFF_W-1:0] ad_bus
);
  // R2
  req_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> pa_valid);

  // R7
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!pa_valid && $stable(pa) && $stable(pa_wrap)));

  // R8
  addr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pa_valid |-> (ale && ad_bus == pa[OFF_W-1:0]));

  // R8
  data_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pa_valid |-> (!ale && ad_bus == bus_dout));

  // R5
  wrap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_valid && pa_wrap) |-> (pa < PA_W'(2**OFF_W)));

  // R9
  para_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_off == '0) |=> (pa[SHIFT-1:0] == '0 && !pa_wrap));
endmodule

bind seg_addr_gen seg_addr_gen_chk #(
  .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .NUM_SEGS(NUM_SEGS)
) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid), .req_off(req_off),
  .bus_dout(bus_dout), .pa(pa), .pa_valid(pa_valid), .pa_wrap(pa_wrap),
  .ale(ale), .ad_bus(ad_bus)
);

// File: tb/seg_addr_gen_tb_top.sv
module seg_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [15:0] wr_data;
  logic        req_valid;
  logic [1:0]  req_sel;
  logic [15:0] req_off;
  logic [15:0] bus_dout;
  logic [19:0] pa;
  logic        pa_valid, pa_wrap, ale;
  logic [15:0] ad_bus;

  int tests = 0;
  int fails = 0;
  logic [15:0] model_seg [4];

  always #4 clk = ~clk;

  seg_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .req_valid(req_valid), .req_sel(req_sel), .req_off(req_off),
    .bus_dout(bus_dout), .pa(pa), .pa_valid(pa_valid), .pa_wrap(pa_wrap),
    .ale(ale), .ad_bus(ad_bus)
  );

  function automatic logic [20:0] model_sum(input logic [15:0] s, input logic [15:0] o);
    return {1'b0, s, 4'h0} + {5'h0, o};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic write_seg(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
    model_seg[sel] = val;
  endtask

  // one request, result checked in the following cycle
  task automatic access(input logic [1:0] sel, input logic [15:0] off, input string req);
    logic [20:0] s;
    @(negedge clk);
    s = model_sum(model_seg[sel], off);
    req_valid = 1'b1; req_sel = sel; req_off = off;
    @(negedge clk);
    req_valid = 1'b0;
    check(pa_valid == 1'b1, req, {31'h0, pa_valid}, 32'h1);
    check(pa == s[19:0], req, {12'h0, pa}, {12'h0, s[19:0]});
    check(pa_wrap == s[20], req, {31'h0, pa_wrap}, {31'h0, s[20]});
  endtask

  task automatic t_reset;
    bus_dout = 16'hA5C3;
    #1;
    check(!pa_valid && !ale, "R1", {30'h0, pa_valid, ale}, 32'h0);
    check(ad_bus == 16'hA5C3, "R1", {16'h0, ad_bus}, 32'hA5C3);
    for (int i = 0; i < 4; i++) access(2'(i), 16'h0000, "R1");
  endtask

  task automatic t_select;
    write_seg(seg_addr_pkg::SEG_CODE,  16'h1000);
    write_seg(seg_addr_pkg::SEG_DATA,  16'h2345);
    write_seg(seg_addr_pkg::SEG_STACK, 16'h8001);
    write_seg(seg_addr_pkg::SEG_EXTRA, 16'hABCD);
    for (int i = 0; i < 4; i++) access(2'(i), 16'h0123, "R3");
    access(2'b01, 16'hFFFF, "R2");
    access(2'b10, 16'h7F0F, "R2");
  endtask

  task automatic t_same_cycle;
    logic [20:0] s_old;
    @(negedge clk);
    s_old = model_sum(model_seg[1], 16'h0010);
    wr_en = 1'b1; wr_sel = 2'b01; wr_data = 16'h4000;
    req_valid = 1'b1; req_sel = 2'b01; req_off = 16'h0010;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    model_seg[1] = 16'h4000;
    check(pa == s_old[19:0], "R4 old value", {12'h0, pa}, {12'h0, s_old[19:0]});
    access(2'b01, 16'h0010, "R4 new value");
    access(2'b00, 16'h0000, "R3 other untouched");
  endtask

  task automatic t_wrap;
    write_seg(2'b11, 16'hFFFF);
    access(2'b11, 16'hFFFF, "R5");
    check(pa == 20'h0FFEF && pa_wrap, "R5 corner", {11'h0, pa_wrap, pa}, 32'h0010_FFEF);
    write_seg(2'b11, 16'hF001);
    access(2'b11, 16'hFFF0, "R5");
    check(pa == 20'h0 && pa_wrap, "R5 exact", {11'h0, pa_wrap, pa}, 32'h0010_0000);
    write_seg(2'b11, 16'hF000);
    access(2'b11, 16'hFFFF, "R5");
    check(pa == 20'hFFFFF && !pa_wrap, "R5 top", {11'h0, pa_wrap, pa}, 32'h000F_FFFF);
  endtask

  task automatic t_overlap;
    write_seg(2'b00, 16'h1234);
    write_seg(2'b10, 16'h1230);
    access(2'b00, 16'h0005, "R6");
    check(pa == 20'h12345 && !pa_wrap, "R6 a", {11'h0, pa_wrap, pa}, 32'h12345);
    access(2'b10, 16'h0045, "R6");
    check(pa == 20'h12345 && !pa_wrap, "R6 b", {11'h0, pa_wrap, pa}, 32'h12345);
  endtask

  task automatic t_phases;
    logic [19:0] held;
    bus_dout = 16'h5A5A;
    access(2'b01, 16'h0ABC, "R2");
    held = pa;
    check(ale && ad_bus == pa[15:0], "R8 address phase", {15'h0, ale, ad_bus},
          {15'h0, 1'b1, pa[15:0]});
    @(negedge clk);
    check(!pa_valid, "R7 pulse", {31'h0, pa_valid}, 32'h0);
    check(pa == held, "R7 hold", {12'h0, pa}, {12'h0, held});
    check(!ale && ad_bus == 16'h5A5A, "R8 data phase", {15'h0, ale, ad_bus}, 32'h5A5A);
    // back-to-back requests
    @(negedge clk);
    req_valid = 1'b1; req_sel = 2'b00; req_off = 16'h0001;
    @(negedge clk);
    check(pa == 20'h12341 && pa_valid, "R7 b2b first", {12'h0, pa}, 32'h12341);
    req_sel = 2'b10; req_off = 16'h0002;
    @(negedge clk);
    req_valid = 1'b0;
    check(pa == 20'h12302 && pa_valid, "R7 b2b second", {12'h0, pa}, 32'h12302);
  endtask

  task automatic t_para;
    write_seg(2'b01, 16'hBEEF);
    access(2'b01, 16'h0000, "R9");
    check(pa[3:0] == 4'h0 && !pa_wrap, "R9", {12'h0, pa}, 32'hBEEF0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    req_valid = 1'b0; req_sel = '0; req_off = '0; bus_dout = '0;
    for (int i = 0; i < 4; i++) model_seg[i] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_select();
    t_same_cycle();
    t_wrap();
    t_overlap();
    t_phases();
    t_para();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule